// File: doc/BRIEF.md
# Amplifier Protection and Mute Controller

This block supervises the output stage of a two-channel switching power amplifier. It takes a mute request, digital over-voltage and under-voltage flags for the supply rails, four over-current flags (high-side and low-side sense for each channel) and one input-overload flag per channel. All of these arrive as asynchronous logic levels. From them it produces a single drive-enable that gates every gate driver of both channels, a shutdown status output that is high whenever the stage is off, and an active-low clipping indicator.

Rail faults and over-current faults are handled differently. A rail fault recovers by itself once the flag drops. An over-current is held in a latch, and only a rising edge of the mute request or a reset clears it. Every return to the enabled state goes through the same unmute delay, whatever caused the stage to turn off. That delay is a counter whose length is derived from the clock frequency and a delay in milliseconds (200 ms by default). It limits on/off chatter when supply pumping trips the rail comparators repeatedly.

Top module: `amp_guard`

## Requirements
- R1: After reset, `drive_en_o` is 0, `hmute_o` is 1 and `overload_n_o` is 1. The mute request is treated as asserted until the synchronisers fill.
- R2: While `mute_i` is 1, `drive_en_o` is 0 and `hmute_o` is 1. Both take effect on the third rising clock edge after the input changes.
- R3: While `rail_ov_i` or `rail_uv_i` is 1, `drive_en_o` is 0 and `hmute_o` is 1, with the same three-edge latency.
- R4: A rail fault is not latched. Once both rail flags are 0, and with no other cause present, `drive_en_o` returns to 1 after the unmute delay.
- R5: Any bit of `oc_hi_i[1:0]` or `oc_lo_i[1:0]` turns the stage off. The fault stays latched after the flag falls.
- R6: The over-current latch is cleared only by a rising edge of the synchronised mute request while no over-current is present. A rail fault or its recovery does not clear it, and an over-current still present when mute falls sets it again.
- R7: Once every shutdown cause is gone, `drive_en_o` rises exactly DELAY_CYC+2 rising edges after the last cause is removed at the input. DELAY_CYC = CLK_HZ/1000*DELAY_MS.
- R8: If mute or any fault reappears during the countdown, the countdown restarts from zero.
- R9: `overload_n_o` is 0 exactly while any bit of `clip_i[1:0]` is 1, delayed by two rising edges. It is not latched.
- R10: `hmute_o` is always the inverse of `drive_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_i | input | 1 | Asynchronous mute request, 1 = mute |
| rail_ov_i | input | 1 | Asynchronous supply over-voltage flag |
| rail_uv_i | input | 1 | Asynchronous supply under-voltage flag |
| oc_hi_i | input | 2 | Per-channel high-side over-current flags |
| oc_lo_i | input | 2 | Per-channel low-side over-current flags |
| clip_i | input | 2 | Per-channel input-overload flags |
| drive_en_o | output | 1 | Shared enable for all gate drives |
| hmute_o | output | 1 | 1 while the output stage is shut off |
| overload_n_o | output | 1 | 0 while any channel is overloaded |

## Verification
Each input passes through two flops. The clipping indicator therefore follows its inputs two edges late. Shutdown appears on the third edge after a mute or fault input changes, and the enable returns DELAY_CYC+2 edges after the last cause is removed. The bench changes inputs just after a rising edge and keeps a behavioural model that records the input history and counts clean cycles. On every falling edge it compares all three outputs with that model, so each result is checked in exactly the cycle it is due, not within a window. The delay is shortened through its parameters so that countdowns, restarts and latch clears all complete many times within the run.

// File: rtl/amp_guard.sv
module amp_guard #(
  parameter int CLK_HZ   = 250_000_000,
  parameter int DELAY_MS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mute_i,
  input  logic       rail_ov_i,
  input  logic       rail_uv_i,
  input  logic [1:0] oc_hi_i,
  input  logic [1:0] oc_lo_i,
  input  logic [1:0] clip_i,
  output logic       drive_en_o,
  output logic       hmute_o,
  output logic       overload_n_o
);
  localparam int DELAY_CYC = CLK_HZ / 1000 * DELAY_MS;
  localparam int CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;

  logic [1:0] mute_sy;
  logic [1:0] rail_sy [2];
  logic [3:0] oc_sy   [2];
  logic [1:0] clip_sy [2];
  logic       mute_d;
  logic       oc_latch;
  logic       en_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_sy <= 2'b11;
      rail_sy[0] <= '0; rail_sy[1] <= '0;
      oc_sy[0]   <= '0; oc_sy[1]   <= '0;
      clip_sy[0] <= '0; clip_sy[1] <= '0;
    end else begin
      mute_sy    <= {mute_sy[0], mute_i};
      rail_sy[0] <= {rail_ov_i, rail_uv_i};
      rail_sy[1] <= rail_sy[0];
      oc_sy[0]   <= {oc_hi_i, oc_lo_i};
      oc_sy[1]   <= oc_sy[0];
      clip_sy[0] <= clip_i;
      clip_sy[1] <= clip_sy[0];
    end
  end

  logic mute_s, rail_bad, oc_now, mute_rise, blocked;
  assign mute_s    = mute_sy[1];
  assign rail_bad  = |rail_sy[1];
  assign oc_now    = |oc_sy[1];
  assign mute_rise = mute_s & ~mute_d;
  assign blocked   = mute_s | rail_bad | oc_now | oc_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_d   <= 1'b1;
      oc_latch <= 1'b0;
    end else begin
      mute_d <= mute_s;
      if (oc_now)         oc_latch <= 1'b1;
      else if (mute_rise) oc_latch <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else if (blocked) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else if (!en_q) begin
      if (cnt == CW'(DELAY_CYC - 1)) en_q <= 1'b1;
      else                           cnt  <= cnt + 1'b1;
    end
  end

  assign drive_en_o   = en_q;
  assign hmute_o      = ~en_q;
  assign overload_n_o = ~|clip_sy[1];

  a_r2_mute_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    mute_s |=> !drive_en_o);
  a_r3_rail_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    rail_bad |=> (!drive_en_o && hmute_o));
  a_r5_oc_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    oc_now |=> oc_latch);
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latch && !mute_rise) |=> oc_latch);
  a_r7_enable_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en_o) |-> ($past(cnt) == CW'(DELAY_CYC - 1)));
  a_r8_restart_on_block: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (cnt == '0));
endmodule

// File: tb/amp_guard_bench.sv
module amp_guard_bench;
  localparam int CLK_HZ = 50_000;
  localparam int DMS    = 1;
  localparam int D      = CLK_HZ / 1000 * DMS;

  logic clk = 0, rst_n = 0;
  logic mute = 1, ov = 0, uv = 0;
  logic [1:0] ochi = 0, oclo = 0, clip = 0;
  logic drive_en, hmute, overload_n;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  amp_guard #(.CLK_HZ(CLK_HZ), .DELAY_MS(DMS)) u_amp_guard (
    .clk(clk), .rst_n(rst_n), .mute_i(mute), .rail_ov_i(ov), .rail_uv_i(uv),
    .oc_hi_i(ochi), .oc_lo_i(oclo), .clip_i(clip),
    .drive_en_o(drive_en), .hmute_o(hmute), .overload_n_o(overload_n));

  // reference: input history, h[0] newest
  logic h_mute [4];
  logic h_rail [4];
  logic h_oc   [4];
  logic h_clip [4];
  logic m_latch, m_en;
  int   m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_mute[i] = 1; h_rail[i] = 0; h_oc[i] = 0; h_clip[i] = 0;
      end
      m_latch = 0; m_en = 0; m_run = 0;
    end else begin
      logic blk;
      for (int i = 3; i > 0; i--) begin
        h_mute[i] = h_mute[i-1]; h_rail[i] = h_rail[i-1];
        h_oc[i] = h_oc[i-1]; h_clip[i] = h_clip[i-1];
      end
      h_mute[0] = mute; h_rail[0] = ov | uv;
      h_oc[0] = |{ochi, oclo}; h_clip[0] = |clip;
      blk = h_mute[2] | h_rail[2] | h_oc[2] | m_latch;
      if (h_oc[2]) m_latch = 1;
      else if (h_mute[2] && !h_mute[3]) m_latch = 0;
      if (blk) begin m_run = 0; m_en = 0; end
      else if (!m_en) begin
        if (m_run == D - 1) m_en = 1; else m_run++;
      end
    end
  end

  always @(negedge clk) begin
    logic exp_ovl;
    exp_ovl = rst_n ? ~h_clip[1] : 1'b1;
    cycles++;
    checks++;
    if (drive_en !== m_en || hmute !== ~m_en || overload_n !== exp_ovl) begin
      fails++;
      $display("FAIL %s (R10 on hmute) cyc %0d: drive_en=%b hmute=%b overload_n=%b expected %b %b %b",
               tag, cycles, drive_en, hmute, overload_n, m_en, ~m_en, exp_ovl);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_en(string r, logic e);
    #1;
    checks++;
    if (drive_en !== e) begin
      fails++;
      $display("FAIL %s spot: drive_en=%b expected %b", r, drive_en, e);
    end
  endtask

  initial begin
    step(4);
    expect_en("R1", 0);
    rst_n = 1;
    tag = "R2"; step(10);
    expect_en("R2", 0);
    tag = "R7"; mute = 0;
    step(D + 1); expect_en("R7", 0);
    step(1);     expect_en("R7", 1);
    step(5);
    tag = "R9";
    clip = 2'b01; step(4); clip = 2'b10; step(3); clip = 2'b11; step(3);
    clip = 2'b00; step(5);
    tag = "R3"; ov = 1; step(6); expect_en("R3", 0);
    tag = "R4"; ov = 0; step(D + 5); expect_en("R4", 1);
    tag = "R3"; uv = 1; step(6);
    tag = "R4"; uv = 0; step(D + 5); expect_en("R4", 1);
    tag = "R2"; mute = 1; step(8); expect_en("R2", 0);
    tag = "R8"; mute = 0; step(D / 2);
    mute = 1; step(3); mute = 0; step(D / 2);
    uv = 1; step(2); uv = 0; step(D / 2); expect_en("R8", 0);
    ochi = 2'b10; step(1); ochi = 0; step(D); expect_en("R8", 0);
    for (int b = 0; b < 4; b++) begin
      tag = "R6"; mute = 1; step(6); mute = 0; step(D + 6);
      tag = "R5";
      if (b < 2) ochi[b] = 1; else oclo[b-2] = 1;
      step(3); ochi = 0; oclo = 0; step(D + 6); expect_en("R5", 0);
      tag = "R6"; ov = 1; step(5); ov = 0; step(D + 6); expect_en("R6", 0);
    end
    tag = "R6"; mute = 1; step(6); mute = 0; step(D + 6); expect_en("R6", 1);
    oclo = 2'b01; step(4); mute = 1; step(6); mute = 0; step(6);
    oclo = 0; step(D + 6); expect_en("R6", 0);
    mute = 1; step(6); mute = 0; step(D + 6); expect_en("R6", 1);
    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule